// File: doc/BRIEF.md
# SDRAM Low-Power Entry Sequencer

This block sits beside an SDRAM controller's command issuer. It decides when the memory goes into a low-power state after traffic stops. It watches a transfer-request line and a transfer-active line. Once both have been low for a programmable idle delay, it asks the issuer for either a self-refresh entry or a power-down entry, depending on the configured mode. When a new transfer request arrives while the memory is in low power, it asks for an exit first and stalls the transfer until the issuer has accepted that exit.

The block also keeps the low-power extended mode register of the SDRAM in line with three configuration fields: output drive strength, temperature-compensated self-refresh, and partial-array self-refresh. These fields are written once when initialization completes. A change made after that is not written straight away. The rewrite is placed just ahead of the next self-refresh entry, and self-refresh entry is taken directly when no field has changed. Each command request stays on the port until the issuer acknowledges it, and only one is outstanding at any time.

Top module: `sdram_lp_seq`

## Requirements
- R1: While reset is applied, and afterwards until `init_done_i` is seen high, `cmd_valid_o` is 0, `xfer_stall_o` is 1 and `in_lowpower_o` is 0.
- R2: When `init_done_i` is seen high, exactly one extended-mode-register request is raised (`cmd_op_o` = 1). It carries `cmd_emr_o` = {drive[1:0], tcsr[1:0], pasr[2:0]}, with drive in bits 6:5, tcsr in bits 4:3 and pasr in bits 2:0. After it is acknowledged, `xfer_stall_o` is 0.
- R3: Count the clock edges from the edge after both `xfer_req_i` and `xfer_active_i` go low up to the edge that raises the entry request. Timeout code 0 gives 1 edge, code 1 gives 65 edges and code 2 gives 129 edges.
- R4: Timeout code 3, or a mode of 0 or 3, never causes a low-power request, however long the idle time.
- R5: A transfer that starts before the delay expires cancels the pending entry and restarts the full delay from the end of that transfer.
- R6: Mode 1 requests self-refresh entry (`cmd_op_o` = 2). Mode 2 requests power-down entry (`cmd_op_o` = 3). `in_lowpower_o` goes to 1 once either request is acknowledged.
- R7: If the three fields differ from the value last written to the mode register, a self-refresh entry is preceded by a mode register request carrying the new value. The self-refresh request follows only after that request is acknowledged.
- R8: If the fields equal the value last written, self-refresh entry is requested directly, with no mode register request.
- R9: Power-down entry never rewrites the mode register. A pending field change is kept and is written before the next self-refresh entry.
- R10: A transfer request while in low power raises an exit request (`cmd_op_o` = 4) with `xfer_stall_o` held at 1. After the exit is acknowledged, `xfer_stall_o` and `in_lowpower_o` return to 0.
- R11: A raised request keeps `cmd_op_o` and `cmd_emr_o` stable until `cmd_ack_i` is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| init_done_i | input | 1 | SDRAM initialization finished |
| xfer_req_i | input | 1 | A transfer wants to start |
| xfer_active_i | input | 1 | A transfer is in progress |
| xfer_stall_o | output | 1 | Transfers must wait |
| lp_mode_i | input | 2 | 0 off, 1 self-refresh, 2 power-down, 3 off |
| timeout_i | input | 2 | Idle delay code (0, 64, 128 cycles; 3 = never) |
| drive_i | input | 2 | Drive strength field |
| tcsr_i | input | 2 | Temperature-compensated refresh field |
| pasr_i | input | 3 | Partial-array refresh field |
| cmd_valid_o | output | 1 | Command request pending |
| cmd_op_o | output | 3 | 1 mode-reg write, 2 self-refresh, 3 power-down, 4 exit |
| cmd_emr_o | output | 7 | Extended mode register value for op 1 |
| cmd_ack_i | input | 1 | Issuer accepts the pending request |
| in_lowpower_o | output | 1 | Memory is in a low-power state |

## Verification
The idle delay is measured for each timeout code from a clean fall of traffic, which separates the three delay lengths and an off-by-one in the counter. An interrupted idle period checks that the count restarts rather than resumes. The field tracking is tried with no change, with a change followed by self-refresh, and with a change followed by power-down. Together these separate an eager rewrite, a lost rewrite and a missing rewrite. Exits are triggered from both low-power states while the requests are held unacknowledged for several cycles, to expose premature advance or drifting values.

// File: rtl/sdram_lp_pkg.sv
package sdram_lp_pkg;
  localparam int TMO_W    = 2;
  localparam int MODE_W   = 2;
  localparam int DRIVE_W  = 2;
  localparam int TCSR_W   = 2;
  localparam int PASR_W   = 3;
  localparam int EMR_W    = DRIVE_W + TCSR_W + PASR_W;
  localparam int OP_W     = 3;
  localparam int IDLE_C1  = 64;
  localparam int IDLE_C2  = 128;
  localparam int CNT_W    = $clog2(IDLE_C2 + 1);

  localparam logic [OP_W-1:0] OP_NONE = 3'd0;
  localparam logic [OP_W-1:0] OP_EMRS = 3'd1;
  localparam logic [OP_W-1:0] OP_SREF = 3'd2;
  localparam logic [OP_W-1:0] OP_PDN  = 3'd3;
  localparam logic [OP_W-1:0] OP_EXIT = 3'd4;

  localparam logic [MODE_W-1:0] MODE_SREF = 2'd1;
  localparam logic [MODE_W-1:0] MODE_PDN  = 2'd2;

  // idle cycles to wait for a timeout code
  function automatic logic [CNT_W-1:0] idle_limit(input logic [TMO_W-1:0] code);
    case (code)
      2'd1:    idle_limit = CNT_W'(IDLE_C1);
      2'd2:    idle_limit = CNT_W'(IDLE_C2);
      default: idle_limit = '0;
    endcase
  endfunction

  // code 3 disables automatic entry
  function automatic logic idle_enabled(input logic [TMO_W-1:0] code);
    idle_enabled = (code != 2'd3);
  endfunction

  function automatic logic [EMR_W-1:0] emr_pack(input logic [DRIVE_W-1:0] drv,
                                                input logic [TCSR_W-1:0]  tc,
                                                input logic [PASR_W-1:0]  pa);
    emr_pack = {drv, tc, pa};
  endfunction
endpackage

// File: rtl/sdram_lp_idle_timer.sv
module sdram_lp_idle_timer
  import sdram_lp_pkg::*;
#(
  parameter int W = CNT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         arm,
  input  logic         busy,
  input  logic [W-1:0] limit,
  output logic         expire
);
  logic [W-1:0] idle_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              idle_cnt <= '0;
    else if (!arm || busy)   idle_cnt <= '0;
    else if (idle_cnt < limit) idle_cnt <= idle_cnt + 1'b1;
  end

  assign expire = arm && !busy && (idle_cnt >= limit);

  // R3: a nonzero delay needs at least one earlier armed idle cycle
  a_r3_no_early: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && limit != '0) |-> $past(arm && !busy));
endmodule

// File: rtl/sdram_lp_emr_track.sv
module sdram_lp_emr_track
  import sdram_lp_pkg::*;
#(
  parameter int W = EMR_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cfg_val,
  input  logic         load,
  input  logic         commit,
  output logic [W-1:0] snap,
  output logic         dirty
);
  logic [W-1:0] written;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap    <= '0;
      written <= '0;
    end else begin
      if (load)   snap    <= cfg_val;
      if (commit) written <= snap;
    end
  end

  assign dirty = (cfg_val != written);
endmodule

// File: rtl/sdram_lp_fsm.sv
module sdram_lp_fsm
  import sdram_lp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_done,
  input  logic              xfer_req,
  input  logic              expire,
  input  logic [MODE_W-1:0] lp_mode,
  input  logic              tmo_ok,
  input  logic              emr_dirty,
  input  logic [EMR_W-1:0]  emr_snap,
  input  logic              cmd_ack,
  output logic              cmd_valid,
  output logic [OP_W-1:0]   cmd_op,
  output logic              snap_load,
  output logic              emr_commit,
  output logic              timer_arm,
  output logic              stall,
  output logic              in_lp
);
  typedef enum logic [2:0] {
    ST_WAIT_INIT, ST_INIT_EMR, ST_NORMAL, ST_SR_EMR,
    ST_SR_ENTER, ST_PD_ENTER, ST_LOWPWR, ST_EXIT
  } st_e;

  st_e state, nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_WAIT_INIT;
    else        state <= nxt;
  end

  always_comb begin
    nxt       = state;
    snap_load = 1'b0;
    case (state)
      ST_WAIT_INIT: if (init_done) begin
        nxt = ST_INIT_EMR; snap_load = 1'b1;
      end
      ST_INIT_EMR:  if (cmd_ack) nxt = ST_NORMAL;
      ST_NORMAL: if (expire) begin
        if (lp_mode == MODE_SREF) begin
          if (emr_dirty) begin nxt = ST_SR_EMR; snap_load = 1'b1; end
          else            nxt = ST_SR_ENTER;
        end else if (lp_mode == MODE_PDN) begin
          nxt = ST_PD_ENTER;
        end
      end
      ST_SR_EMR:   if (cmd_ack) nxt = ST_SR_ENTER;
      ST_SR_ENTER: if (cmd_ack) nxt = ST_LOWPWR;
      ST_PD_ENTER: if (cmd_ack) nxt = ST_LOWPWR;
      ST_LOWPWR:   if (xfer_req) nxt = ST_EXIT;
      ST_EXIT:     if (cmd_ack) nxt = ST_NORMAL;
      default:     nxt = ST_WAIT_INIT;
    endcase
  end

  always_comb begin
    case (state)
      ST_INIT_EMR, ST_SR_EMR: cmd_op = OP_EMRS;
      ST_SR_ENTER:            cmd_op = OP_SREF;
      ST_PD_ENTER:            cmd_op = OP_PDN;
      ST_EXIT:                cmd_op = OP_EXIT;
      default:                cmd_op = OP_NONE;
    endcase
  end

  assign cmd_valid  = (cmd_op != OP_NONE);
  assign emr_commit = cmd_ack && (state == ST_INIT_EMR || state == ST_SR_EMR);
  assign timer_arm  = (state == ST_NORMAL) && tmo_ok &&
                      (lp_mode == MODE_SREF || lp_mode == MODE_PDN);
  assign stall      = (state != ST_NORMAL);
  assign in_lp      = (state == ST_LOWPWR) || (state == ST_EXIT);

  // R11: request held with the same op until acknowledged
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ack) |=> (cmd_valid && $stable(cmd_op)));
  // R11: mode register payload stays put while unacknowledged
  a_r11_emr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_EMRS && !cmd_ack) |=> $stable(emr_snap));
  // R7/R8: self-refresh only requested when the register is up to date
  a_r8_sref_clean: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_valid && cmd_op == OP_SREF) |-> ($past(emr_commit) || !$past(emr_dirty)));
  // R10: exit requested only on traffic
  a_r10_exit_on_req: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_valid && cmd_op == OP_EXIT) |-> $past(xfer_req));
  // R6: low power entered only through an acknowledged entry request
  a_r6_entry_acked: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_lp) |-> $past(cmd_ack && (cmd_op == OP_SREF || cmd_op == OP_PDN)));
endmodule

// File: rtl/sdram_lp_seq.sv
module sdram_lp_seq
  import sdram_lp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       init_done_i,
  input  logic       xfer_req_i,
  input  logic       xfer_active_i,
  output logic       xfer_stall_o,
  input  logic [1:0] lp_mode_i,
  input  logic [1:0] timeout_i,
  input  logic [1:0] drive_i,
  input  logic [1:0] tcsr_i,
  input  logic [2:0] pasr_i,
  output logic       cmd_valid_o,
  output logic [2:0] cmd_op_o,
  output logic [6:0] cmd_emr_o,
  input  logic       cmd_ack_i,
  output logic       in_lowpower_o
);
  logic             busy, expire, timer_arm, tmo_ok;
  logic             snap_load, emr_commit, emr_dirty;
  logic [EMR_W-1:0] cfg_emr, emr_snap;
  logic [CNT_W-1:0] limit;

  assign busy    = xfer_req_i || xfer_active_i;
  assign tmo_ok  = idle_enabled(timeout_i);
  assign limit   = idle_limit(timeout_i);
  assign cfg_emr = emr_pack(drive_i, tcsr_i, pasr_i);

  sdram_lp_idle_timer #(.W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .arm(timer_arm), .busy(busy),
    .limit(limit), .expire(expire)
  );

  sdram_lp_emr_track #(.W(EMR_W)) u_track (
    .clk(clk), .rst_n(rst_n), .cfg_val(cfg_emr), .load(snap_load),
    .commit(emr_commit), .snap(emr_snap), .dirty(emr_dirty)
  );

  sdram_lp_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .init_done(init_done_i), .xfer_req(xfer_req_i),
    .expire(expire), .lp_mode(lp_mode_i), .tmo_ok(tmo_ok),
    .emr_dirty(emr_dirty), .emr_snap(emr_snap), .cmd_ack(cmd_ack_i),
    .cmd_valid(cmd_valid_o), .cmd_op(cmd_op_o), .snap_load(snap_load),
    .emr_commit(emr_commit), .timer_arm(timer_arm), .stall(xfer_stall_o),
    .in_lp(in_lowpower_o)
  );

  assign cmd_emr_o = emr_snap;

  // R4: code 3 never lets the idle timer fire
  a_r4_code3_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout_i == 2'd3) |-> !expire);
endmodule

// File: tb/sim_sdram_lp_seq.sv
module sim_sdram_lp_seq;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic init_done = 1'b0, xfer_req = 1'b0, xfer_active = 1'b0, ack = 1'b0;
  logic [1:0] lp_mode = 2'd0, timeout = 2'd3, drive = 2'd2, tcsr = 2'd1;
  logic [2:0] pasr = 3'd5;
  logic stall, cvalid, inlp;
  logic [2:0] cop;
  logic [6:0] cemr;
  int n_run = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_lp_seq u0 (
    .clk(clk), .rst_n(rst_n), .init_done_i(init_done), .xfer_req_i(xfer_req),
    .xfer_active_i(xfer_active), .xfer_stall_o(stall), .lp_mode_i(lp_mode),
    .timeout_i(timeout), .drive_i(drive), .tcsr_i(tcsr), .pasr_i(pasr),
    .cmd_valid_o(cvalid), .cmd_op_o(cop), .cmd_emr_o(cemr), .cmd_ack_i(ack),
    .in_lowpower_o(inlp)
  );

  function automatic logic [6:0] emr_of(input logic [1:0] d, input logic [1:0] t,
                                         input logic [2:0] p);
    return (7'(d) << 5) | (7'(t) << 3) | 7'(p);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // wait for a request, check it, hold it unacknowledged, then acknowledge
  task automatic take_cmd(input int op, input int emr, input string req);
    int waited = 0;
    while (!cvalid && waited < 400) begin @(negedge clk); waited++; end
    chk(cvalid, req, cvalid, 1);
    chk(cop == op[2:0], req, cop, op);
    if (op == 1) chk(cemr == emr[6:0], req, cemr, emr);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(cvalid && cop == op[2:0], "R11", cop, op);
      if (op == 1) chk(cemr == emr[6:0], "R11", cemr, emr);
    end
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
  endtask

  // drop traffic and count edges until a request appears
  task automatic idle_latency(input int exp, input string req);
    int n = 0;
    xfer_active = 1'b0;
    while (n < 300) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (cvalid) break;
    end
    chk(n == exp, req, n, exp);
  endtask

  task automatic do_exit(input string req);
    xfer_req = 1'b1;
    @(negedge clk);
    chk(stall == 1'b1, req, stall, 1);
    take_cmd(4, 0, req);
    chk(stall == 1'b0 && inlp == 1'b0, req, {stall, inlp}, 0);
    xfer_active = 1'b1;
    xfer_req = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!cvalid && stall && !inlp, "R1", {cvalid, stall, inlp}, 2);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(!cvalid && stall && !inlp, "R1", {cvalid, stall, inlp}, 2);
  endtask

  task automatic t_init();
    init_done = 1'b1;
    take_cmd(1, emr_of(2'd2, 2'd1, 3'd5), "R2");
    chk(stall == 1'b0, "R2", stall, 0);
    chk(!cvalid, "R2", cvalid, 0);
  endtask

  task automatic t_no_entry();
    bit seen = 0;
    lp_mode = 2'd1;
    for (int i = 0; i < 300; i++) begin @(negedge clk); seen |= cvalid; end
    chk(!seen, "R4", seen, 0);
    lp_mode = 2'd3; timeout = 2'd0;
    for (int i = 0; i < 20; i++) begin @(negedge clk); seen |= cvalid; end
    chk(!seen, "R4", seen, 0);
    lp_mode = 2'd0;
    for (int i = 0; i < 20; i++) begin @(negedge clk); seen |= cvalid; end
    chk(!seen, "R4", seen, 0);
  endtask

  task automatic t_restart();
    bit seen = 0;
    xfer_active = 1'b1; timeout = 2'd1; lp_mode = 2'd1;
    repeat (3) @(negedge clk);
    xfer_active = 1'b0;
    for (int i = 0; i < 50; i++) begin @(negedge clk); seen |= cvalid; end
    xfer_active = 1'b1;
    repeat (2) @(negedge clk);
    chk(!seen, "R5", seen, 0);
    idle_latency(65, "R5");
    chk(cop == 3'd2, "R8", cop, 2);
    take_cmd(2, 0, "R8");
    chk(inlp == 1'b1, "R6", inlp, 1);
    do_exit("R10");
  endtask

  task automatic t_codes();
    timeout = 2'd0; lp_mode = 2'd2;
    @(negedge clk);
    idle_latency(1, "R3");
    take_cmd(3, 0, "R6");
    chk(inlp == 1'b1, "R6", inlp, 1);
    do_exit("R10");
    timeout = 2'd2; lp_mode = 2'd1;
    @(negedge clk);
    idle_latency(129, "R3");
    take_cmd(2, 0, "R3");
    do_exit("R10");
  endtask

  task automatic t_dirty();
    timeout = 2'd0; lp_mode = 2'd1; pasr = 3'd3;
    @(negedge clk);
    idle_latency(1, "R7");
    take_cmd(1, emr_of(2'd2, 2'd1, 3'd3), "R7");
    chk(cvalid && cop == 3'd2, "R7", cop, 2);
    take_cmd(2, 0, "R7");
    do_exit("R10");
    idle_latency(1, "R8");
    take_cmd(2, 0, "R8");
    do_exit("R10");
  endtask

  task automatic t_pd_dirty();
    timeout = 2'd0; lp_mode = 2'd2; drive = 2'd1;
    @(negedge clk);
    idle_latency(1, "R9");
    take_cmd(3, 0, "R9");
    do_exit("R9");
    lp_mode = 2'd1;
    @(negedge clk);
    idle_latency(1, "R9");
    take_cmd(1, emr_of(2'd1, 2'd1, 3'd3), "R9");
    take_cmd(2, 0, "R9");
    do_exit("R10");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run + 1, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_init();
    t_no_entry();
    t_restart();
    t_codes();
    t_dirty();
    t_pd_dirty();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule